// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a watchdog counter that runs on the peripheral clock. It starts at zero when the block comes out of reset and after every accepted feed, and it counts up by one on each clock. Two 4-bit timeout codes sit in a control register. One sets how long the counter may run before the watchdog interrupt is raised. The other sets how long it may run before a system reset is requested. A shorter code value gives a longer timeout. Each timeout is a power of two, so a threshold check is one comparison against a single set bit.

Software keeps the watchdog quiet by writing an ordered two-value key to the feed register. The unlock value arms the key logic, and the fire value written while armed restarts the counter. Any other value written to the feed register drops the armed state. Writes to the control register never disturb the count. The interrupt stays high until a valid feed arrives. The reset request is a one-cycle pulse, after which the counter starts again from zero.

The key logic has two named states: KEY_IDLE and KEY_ARMED. Its transitions are:
- arm (KEY_IDLE to KEY_ARMED, on a feed-register write of 0xA5);
- rearm (KEY_ARMED to itself, on 0xA5);
- fire (KEY_ARMED to KEY_IDLE, on 0x5A, which feeds the watchdog);
- break (KEY_ARMED to KEY_IDLE, on any other feed-register value);
- stay (KEY_IDLE to itself, on any value except 0xA5).

The timer sequencer also has two named states: WD_COUNT and WD_BITE. Its transitions are:
- bite (WD_COUNT to WD_BITE, when the count reaches the reset threshold and no feed arrives on that edge);
- recover (WD_BITE to WD_COUNT, always after one cycle).

Top module: `wdt_keyed`

## Requirements
- R1: The control register sits at byte offset 0x00. Bits 3:0 hold the interrupt timeout code and bits 7:4 hold the reset timeout code. Both codes reset to 0. A read returns the two codes in bits 7:0 and zero in bits 31:8. Written bits 31:8 are dropped.
- R2: Both codes use the same mapping. Code c gives a timeout of 2^(MIN_EXP+15-c) clock cycles. With the default MIN_EXP of 16, code 0xF gives 2^16 cycles and code 0x0 gives 2^31 cycles.
- R3: The interrupt rises on the clock edge that follows the count reaching the interrupt threshold. Measured from the edge of the last feed, this is threshold+1 edges later, provided no valid feed arrives in between.
- R4: A valid feed is a write of 0x5A to offset 0x04 while the key is armed. The key is armed by a write of 0xA5 to the same offset, and repeated 0xA5 writes keep it armed. A valid feed restarts the count at zero and clears the interrupt on the same edge.
- R5: Once raised, the interrupt stays high until a valid feed. A reset request does not clear it.
- R6: The reset request goes high for exactly one cycle. It starts on the edge that follows the count reaching the reset threshold, which is threshold+1 edges after the last feed. The count then restarts at zero.
- R7: Any value other than 0xA5 or 0x5A written to offset 0x04 disarms the key without feeding. A 0x5A written while unarmed does nothing. So the pair written in the wrong order, or a stray feed-register write between the two key values, leaves the count running.
- R8: A control-register write changes the thresholds from the next edge on. It does not restart or pause the count.
- R9: Offset 0x04 reads as zero in all 32 bits. Any other offset reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock; the counter advances once per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq | output | 1 | Watchdog interrupt, held until a valid feed |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A fault in the key state machine shows up as a timing error in the thresholds. If it wrongly accepts a key, the interrupt rises late. If it wrongly rejects a key, the interrupt rises early. Either way the error appears at the threshold edge after the bad write, so the bench measures interrupt and reset latency in edges from the last real feed. A counter that clears on a control write, or fails to clear after a bite, moves every later edge. A per-cycle reference model catches that on the first cycle where irq or rst_req differs.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam int CODE_W = 4;
    localparam int REG_W  = 8;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_FEED = 8'h04;

    localparam logic [REG_W-1:0] KEY_UNLOCK = 8'hA5;
    localparam logic [REG_W-1:0] KEY_FIRE   = 8'h5A;

    typedef enum logic [0:0] {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    typedef enum logic [0:0] {
        WD_COUNT = 1'b0,
        WD_BITE  = 1'b1
    } wd_state_e;

endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
    import wdk_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CODE_W-1:0] int_code,
    output logic [CODE_W-1:0] rst_code,
    output logic              feed_pulse
);

    localparam int PAD_W = DATA_W - REG_W;

    logic             sel_ctrl;
    logic             sel_feed;
    logic             wr_ctrl;
    logic             wr_feed;
    logic [REG_W-1:0] wr_byte;
    logic [REG_W-1:0] ctrl_q;

    key_state_e key_state;
    key_state_e key_next;

    assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_feed = (bus_addr == ADDR_W'(OFS_FEED));
    assign wr_ctrl  = bus_we && sel_ctrl;
    assign wr_feed  = bus_we && sel_feed;
    assign wr_byte  = bus_wdata[REG_W-1:0];

    // control register: both timeout codes, effective from the next edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wr_byte;
        end
    end

    assign int_code = ctrl_q[CODE_W-1:0];
    assign rst_code = ctrl_q[2*CODE_W-1:CODE_W];

    // read mux: only the control byte is visible, everything else is zero
    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata = {{PAD_W{1'b0}}, ctrl_q};
        end
    end

    // key state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_state <= KEY_IDLE;
        end else begin
            key_state <= key_next;
        end
    end

    // key transitions: arm, rearm, fire, break, stay
    always_comb begin
        key_next = key_state;
        if (wr_feed) begin
            unique case (key_state)
                KEY_IDLE: begin
                    if (wr_byte == KEY_UNLOCK) key_next = KEY_ARMED;
                    else                       key_next = KEY_IDLE;
                end
                KEY_ARMED: begin
                    if (wr_byte == KEY_UNLOCK) key_next = KEY_ARMED;
                    else                       key_next = KEY_IDLE;
                end
                default: key_next = KEY_IDLE;
            endcase
        end
    end

    // key outputs: the fire transition is the feed
    always_comb begin
        feed_pulse = 1'b0;
        unique case (key_state)
            KEY_IDLE:  feed_pulse = 1'b0;
            KEY_ARMED: feed_pulse = wr_feed && (wr_byte == KEY_FIRE);
            default:   feed_pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdk_thresh.sv
module wdk_thresh
    import wdk_pkg::*;
#(
    parameter int MIN_EXP = 16,
    parameter int CNT_W   = MIN_EXP + 16
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CNT_W-1:0]  count,
    output logic              reached
);

    localparam int TOP_EXP = MIN_EXP + (1 << CODE_W) - 1;

    logic [CNT_W-1:0] limit;
    int unsigned      bit_pos;

    // inverted code: the largest code selects the shortest timeout
    always_comb begin
        bit_pos = TOP_EXP - int'(code);
        limit   = CNT_W'(1) << bit_pos;
        reached = (count >= limit);
    end

endmodule

// File: rtl/wdk_core.sv
module wdk_core
    import wdk_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             feed,
    input  logic             int_hit,
    input  logic             rst_hit,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             rst_req
);

    wd_state_e wd_state;
    wd_state_e wd_next;
    logic      irq_q;

    // timer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_state <= WD_COUNT;
        end else begin
            wd_state <= wd_next;
        end
    end

    // timer transitions: bite, recover
    always_comb begin
        wd_next = wd_state;
        unique case (wd_state)
            WD_COUNT: if (rst_hit && !feed) wd_next = WD_BITE;
            WD_BITE:  wd_next = WD_COUNT;
            default:  wd_next = WD_COUNT;
        endcase
    end

    // counter: restarts on feed and after a bite, never on control writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (feed || (wd_state == WD_BITE)) begin
            count <= '0;
        end else begin
            count <= count + CNT_W'(1);
        end
    end

    // sticky interrupt flag, cleared only by a feed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (feed) begin
            irq_q <= 1'b0;
        end else if ((wd_state == WD_COUNT) && int_hit) begin
            irq_q <= 1'b1;
        end
    end

    // timer outputs
    always_comb begin
        irq     = irq_q;
        rst_req = 1'b0;
        unique case (wd_state)
            WD_COUNT: rst_req = 1'b0;
            WD_BITE:  rst_req = 1'b1;
            default:  rst_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdk_pkg::*;
#(
    parameter int MIN_EXP = 16,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);

    localparam int CNT_W  = MIN_EXP + (1 << CODE_W);
    localparam int N_THR  = 2;

    logic [CODE_W-1:0] int_code;
    logic [CODE_W-1:0] rst_code;
    logic              feed_pulse;
    logic [CNT_W-1:0]  count;
    logic [CODE_W-1:0] codes [N_THR];
    logic [N_THR-1:0]  hits;

    wdk_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .int_code   (int_code),
        .rst_code   (rst_code),
        .feed_pulse (feed_pulse)
    );

    assign codes[0] = int_code;
    assign codes[1] = rst_code;

    for (genvar g = 0; g < N_THR; g++) begin : g_thr
        wdk_thresh #(
            .MIN_EXP (MIN_EXP),
            .CNT_W   (CNT_W)
        ) u_thr (
            .code    (codes[g]),
            .count   (count),
            .reached (hits[g])
        );
    end

    wdk_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .feed    (feed_pulse),
        .int_hit (hits[0]),
        .rst_hit (hits[1]),
        .count   (count),
        .irq     (irq),
        .rst_req (rst_req)
    );

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             feed,
    input logic             irq,
    input logic             rst_req,
    input logic [CNT_W-1:0] cnt
);

    AST_BITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R6

    AST_BITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (cnt == '0)); // R6

    AST_FEED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        feed |=> (!irq && !rst_req && cnt == '0)); // R4

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !feed) |=> irq); // R5

    AST_COUNT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!feed && !rst_req) |=> (cnt == $past(cnt) + CNT_W'(1))); // R8

endmodule

bind wdt_keyed wdt_keyed_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .feed    (feed_pulse),
    .irq     (irq),
    .rst_req (rst_req),
    .cnt     (count)
);

// File: tb/wdt_keyed_test.sv
module wdt_keyed_test;

    localparam int MIN_EXP = 4;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;
    logic              rst_req;

    int checks = 0;
    int fails  = 0;
    longint cyc = 0;
    longint feed_cyc = 0;

    // reference model state
    longint    m_count = 0;
    bit        m_irq   = 0;
    bit        m_bite  = 0;
    bit        m_armed = 0;
    bit [7:0]  m_ctrl  = 8'h00;

    always #2 clk = ~clk;

    wdt_keyed #(
        .MIN_EXP (MIN_EXP),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    function automatic longint thr(input int code);
        return longint'(1) << (MIN_EXP + 15 - code);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural model, one step per clock edge
    always @(posedge clk) begin
        cyc++;
        if (rst_n) begin
            automatic bit fw   = bus_we && (bus_addr == 8'h04);
            automatic bit feed = fw && m_armed && (bus_wdata[7:0] == 8'h5A);
            automatic longint ti = thr(int'(m_ctrl[3:0]));
            automatic longint tr = thr(int'(m_ctrl[7:4]));
            if (fw) m_armed = (bus_wdata[7:0] == 8'hA5);
            if (bus_we && bus_addr == 8'h00) m_ctrl = bus_wdata[7:0];
            if (feed) begin
                m_count = 0; m_irq = 0; m_bite = 0;
            end else if (m_bite) begin
                m_count = 0; m_bite = 0;
            end else begin
                if (m_count >= ti) m_irq = 1;
                if (m_count >= tr) m_bite = 1;
                m_count++;
            end
        end
    end

    // compare outputs with the model shortly after every edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            check(irq == m_irq, "R3/R5 irq vs model", longint'(irq), longint'(m_irq));
            check(rst_req == m_bite, "R6 rst_req vs model", longint'(rst_req), longint'(m_bite));
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic do_feed();
        bus_wr(8'h04, 32'hA5);
        bus_wr(8'h04, 32'h5A);
        feed_cyc = cyc;
    endtask

    // returns edges from the last feed until the chosen output is high
    task automatic wait_high(input bit want_rst, output longint lat);
        lat = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if ((want_rst ? rst_req : irq) == 1'b1) begin
                lat = cyc - feed_cyc;
                break;
            end
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        longint lat;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R9 other offsets
        bus_rd(8'h00, rd);
        check(rd == 32'h0, "R1 ctrl reset", rd, 0);
        check(irq == 1'b0 && rst_req == 1'b0, "R1 outputs idle after reset", {irq, rst_req}, 0);
        bus_wr(8'hF8, 32'h0000_00FF);
        bus_rd(8'h00, rd);
        check(rd == 32'h0, "R9 unmapped write ignored", rd, 0);
        bus_rd(8'hF8, rd);
        check(rd == 32'h0, "R9 unmapped reads zero", rd, 0);

        // R1 upper bits dropped, field readback
        bus_wr(8'h00, 32'hFFFF_FFEF);
        bus_rd(8'h00, rd);
        check(rd == 32'h0000_00EF, "R1 ctrl readback", rd, 32'hEF);
        bus_wr(8'h04, 32'h0000_00A5);
        bus_rd(8'h04, rd);
        check(rd == 32'h0, "R9 feed reads zero", rd, 0);
        bus_wr(8'h04, 32'h0000_0000);

        // R2 R3 R6: int code F, reset code E
        do_feed();
        wait_high(1'b0, lat);
        check(lat == thr(15) + 1, "R3 irq latency code F", lat, thr(15) + 1);
        wait_high(1'b1, lat);
        check(lat == thr(14) + 1, "R2 R6 bite latency code E", lat, thr(14) + 1);
        @(negedge clk);
        check(rst_req == 1'b0, "R6 bite lasts one cycle", rst_req, 0);
        check(irq == 1'b1, "R5 irq survives bite", irq, 1);
        repeat (5) @(negedge clk);
        check(irq == 1'b1, "R5 irq held", irq, 1);

        // R4 feed with a repeated unlock clears irq
        bus_wr(8'h04, 32'hA5);
        bus_wr(8'h04, 32'hA5);
        bus_wr(8'h04, 32'h5A);
        feed_cyc = cyc;
        check(irq == 1'b0, "R4 feed clears irq", irq, 0);

        // R7 wrong order
        wait_high(1'b1, lat);
        do_feed();
        bus_wr(8'h04, 32'h5A);
        bus_wr(8'h04, 32'hA5);
        wait_high(1'b0, lat);
        check(lat == thr(15) + 1, "R7 wrong order does not feed", lat, thr(15) + 1);
        bus_wr(8'h04, 32'h00);

        // R7 stray write between the key values
        do_feed();
        bus_wr(8'h04, 32'hA5);
        bus_wr(8'h04, 32'h33);
        bus_wr(8'h04, 32'h5A);
        wait_high(1'b0, lat);
        check(lat == thr(15) + 1, "R7 broken key does not feed", lat, thr(15) + 1);

        // R8 control write mid-count: int code E, reset code D
        do_feed();
        bus_wr(8'h00, 32'hDE);
        wait_high(1'b0, lat);
        check(lat == thr(14) + 1, "R8 ctrl write keeps count", lat, thr(14) + 1);
        wait_high(1'b1, lat);
        check(lat == thr(13) + 1, "R8 new reset code applies", lat, thr(13) + 1);

        // R2 both codes F: irq and bite on the same edge
        bus_wr(8'h00, 32'hFF);
        do_feed();
        wait_high(1'b0, lat);
        check(lat == thr(15) + 1, "R2 irq code F shortest", lat, thr(15) + 1);
        check(rst_req == 1'b1, "R2 bite code F shortest", rst_req, 1);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule